// File: doc/BRIEF.md
# Five-Way Holding Priority Arbiter

This block chooses one of five requesters with a small state machine. It has one idle state and one grant state for each requester. When no grant is held, it grants the highest-priority requester whose request is active. Requester 0 ranks highest and requester 4 lowest. Once a requester holds the grant, it keeps it for as long as its request stays high. A higher-priority request that arrives later does not take the grant away. Priority only matters when a new grant is chosen.

The grant outputs are decoded directly from the registered state, so each grant appears one clock after the state is chosen. When the held request drops, the machine moves straight to the highest-priority request still active. If none is active, it returns to idle. Reset is synchronous and active-high.

Top module: `hold_prio_arb`

## Requirements
- R1: While rst is 1 at a clock edge, the next state is idle and gnt is 5'b00000 after that edge.
- R2: From idle, if req is nonzero at an edge, gnt after that edge is one-hot at the lowest set index of req; bit 0 has the highest priority.
- R3: While the holder's request bit stays 1, gnt stays unchanged, whatever the other request bits do.
- R4: When the holder's request bit is 0 at an edge, gnt after that edge selects the lowest set index among the remaining request bits.
- R5: When no request is active at an edge, gnt is 5'b00000 after that edge.
- R6: At most one bit of gnt is 1 in every cycle.
- R7: gnt bit k is 1 only when req bit k was 1 at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 5 | Request lines; bit 0 has the highest priority |
| gnt | output | 5 | One-hot grant lines, decoded from the state |

## Verification
The two functions that can fall in the same cycle are the hold of a current grant and the priority choice for a higher-ranked newcomer. The bench drives a low-priority holder together with a newly raised higher-priority request and checks that the grant does not move. It then drops the holder while several requests stay high. The next grant must go to the highest-ranked of those remaining requests, which shows that release and re-selection happen in the same edge without passing through idle.

// File: rtl/hold_prio_arb.sv
module hold_prio_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int SW = $clog2(N + 1);
  localparam logic [SW-1:0] IDLE = '0;

  logic [SW-1:0] state, pick, nxt;
  logic          held;

  always_comb begin
    pick = IDLE;
    for (int k = N - 1; k >= 0; k--)
      if (req[k]) pick = SW'(k + 1);
  end

  assign held = (state != IDLE) && req[state - SW'(1)];
  assign nxt  = held ? state : pick;

  always_ff @(posedge clk)
    if (rst) state <= IDLE;
    else     state <= nxt;

  for (genvar k = 0; k < N; k++) begin : g_dec
    assign gnt[k] = (state == SW'(k + 1));
  end

  p_onehot_r6: assert property (@(posedge clk) $onehot0(gnt));

  p_reset_r1: assert property (@(posedge clk) rst |=> (gnt == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((gnt & req) != '0) |=> $stable(gnt));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (gnt == '0));

  p_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0) |-> (($past(req) & gnt) == gnt));

  p_prio_r2: assert property (@(posedge clk) disable iff (rst)
    ((gnt == '0) && (req != '0)) |=> (gnt == (($past(req)) & (~($past(req)) + 1'b1))));
endmodule

// File: tb/test_hold_prio_arb.sv
module test_hold_prio_arb;
  logic clk = 0, rst = 1;
  logic [4:0] req = '0;
  logic [4:0] gnt;
  int n_cmp = 0, n_bad = 0;

  hold_prio_arb i_hold_prio_arb (.clk(clk), .rst(rst), .req(req), .gnt(gnt));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [4:0] exp);
    n_cmp++;
    if (gnt !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
    end
  endtask

  task automatic step(input logic [4:0] r);
    req = r;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1; step(5'b11111); chk("R1 reset", 5'b00000);
    rst = 0;
  endtask

  task automatic t_prio;
    step(5'b00000); chk("R5 idle", 5'b00000);
    step(5'b10100); chk("R2 pick idx2", 5'b00100);
    step(5'b00000); chk("R5 back idle", 5'b00000);
    step(5'b11111); chk("R2 pick idx0", 5'b00001);
    step(5'b00000);
    step(5'b10000); chk("R2 pick idx4", 5'b10000);
    step(5'b00000);
  endtask

  task automatic t_hold;
    step(5'b01000); chk("R3 grant idx3", 5'b01000);
    step(5'b01011); chk("R3 hold vs higher", 5'b01000);
    step(5'b11111); chk("R3 hold all", 5'b01000);
    step(5'b10110); chk("R4 release to idx1", 5'b00010);
    step(5'b10100); chk("R4 release to idx2", 5'b00100);
    step(5'b10000); chk("R4 release to idx4", 5'b10000);
    step(5'b00000); chk("R5 release to idle", 5'b00000);
  endtask

  task automatic t_legal;
    for (int k = 0; k < 5; k++) begin
      step(5'b00001 << k); chk("R7 single", 5'b00001 << k);
      n_cmp++;
      if (!$onehot0(gnt)) begin n_bad++; $display("FAIL R6: gnt=%b expected onehot0", gnt); end
      step(5'b00000); chk("R7 drop", 5'b00000);
    end
    step(5'b00010);
    rst = 1; step(5'b00010); chk("R1 mid-hold reset", 5'b00000);
    rst = 0;
  endtask

  initial begin
    fork
      begin t_reset; t_prio; t_hold; t_legal; end
      begin repeat (5000) @(posedge clk); n_cmp++; n_bad++; $display("FAIL watchdog: expected=done"); end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule